// File: doc/BRIEF.md
# USB PHY PLL Feedback Divider Programmer

This block is a small bus master that sets the feedback divider of a USB 2.0 PHY PLL. The PLL control word sits in a clock and reset register block that only accepts changes while a key is open. A pulse on `start` launches one programming pass. The block captures the reference clock frequency in Hz and reads the PLL control word to recover the pre-divider. It then works out the feedback divider that puts the VCO at 1.92 GHz. Last, it opens the key, rewrites the divider field and closes the key.

The block performs the division serially, so no wide combinational divider is needed. It refuses to touch the register block in two cases: when the reference rate is zero, and when the computed divider does not fit its field. Every pass ends with a single-cycle `done`. `error` rises in that same cycle when the pass was refused. Each register access is one beat: the request and its address, direction and data stay asserted until the register block acknowledges.

Top module: `usbpll_div_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `bus_req` are all low.
- R2: A start with `ref_hz` equal to zero produces `done` with `error` high and no bus access of any kind.
- R3: A successful pass makes exactly four accesses, in this order: read at byte offset 0x164 (control), write 0x0000EA68 to offset 0x180 (key), write to 0x164, write 0x00000000 to 0x180. The control word is written only while the key is open.
- R4: The pre-divider is the 3-bit field at bits 14:12 of the control word that was read. When that field is zero, the value 8 is used in its place.
- R5: The feedback divider written into bits 11:2 equals floor(1,920,000,000 × pre-divider / `ref_hz`).
- R6: In the control write, every bit outside 11:2 equals the value that was read.
- R7: If the computed divider exceeds 1023, the pass ends with `error` high after the control read, with no write at all (no key write either).
- R8: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` keep their values into the next cycle. An access completes in the cycle where `bus_ack` is high.
- R9: `done` is high for exactly one cycle per pass. `error` is never high without `done`.
- R10: A `start` that arrives while `busy` is high has no effect. The pass in progress uses the rate captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one programming pass (ignored while busy) |
| ref_hz | input | 32 | Reference clock rate in Hz, captured at start |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| error | output | 1 | High with `done` when the pass was refused |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | Byte offset inside the register block |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | input | 1 | Access complete |

## Verification
The assertions check several properties on every cycle. They check that an unacknowledged request holds steady and that `done` never lasts two cycles. They check that `error` only appears alongside `done` and that the control word is never written outside an open key window. They also check that each finished division satisfies quotient × divisor + remainder = dividend, and that a start received while busy leaves the captured rate untouched.

Other behaviour only the bench scenarios can show. This covers the exact access order and data, and the substitution of 8 for a zero pre-divider field. It also covers the refusal paths at the 1023/1024 divider boundary and for a zero rate, and the preservation of the unrelated control bits across random control words. The bench checks these against a register-block model that acknowledges after random delays.

// File: rtl/usbpll_pkg.sv
package usbpll_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_CTRL,
    S_DIV_GO,
    S_DIV_WAIT,
    S_WR_UNLOCK,
    S_WR_CTRL,
    S_WR_LOCK
  } seq_state_t;

endpackage

// File: rtl/usbpll_divider.sv
module usbpll_divider #(
  parameter int N_W = 34,
  parameter int D_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [N_W-1:0] quotient
);
  localparam int CNT_W = $clog2(N_W + 1);
  localparam int P_W   = N_W + D_W;

  logic [N_W-1:0]   quo_q;
  logic [D_W-1:0]   rem_q;
  logic [D_W-1:0]   dvs_q;
  logic [N_W-1:0]   dvd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [D_W:0]     trial;
  logic             fits;

  assign trial = {rem_q, quo_q[N_W-1]};
  assign fits  = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      dvd_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        quo_q <= dividend;
        dvd_q <= dividend;
        dvs_q <= divisor;
        rem_q <= '0;
        cnt_q <= CNT_W'(N_W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? D_W'(trial - {1'b0, dvs_q}) : trial[D_W-1:0];
        quo_q <= {quo_q[N_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;

  // R5: a finished division is exact and its remainder is below the divisor
  p_div_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((P_W'(quo_q) * P_W'(dvs_q) + P_W'(rem_q)) == P_W'(dvd_q)) && (rem_q < dvs_q));

endmodule

// File: rtl/usbpll_ctl_field.sv
module usbpll_ctl_field #(
  parameter int DATA_W    = 32,
  parameter int NDIV_LSB  = 2,
  parameter int NDIV_W    = 10,
  parameter int PDIV_LSB  = 12,
  parameter int PDIV_W    = 3,
  parameter int PDIV_DFLT = 8
) (
  input  logic [DATA_W-1:0] ctrl_rd,
  input  logic [NDIV_W-1:0] ndiv,
  output logic [PDIV_W:0]   prediv,
  output logic [DATA_W-1:0] ctrl_wr
);
  localparam logic [DATA_W-1:0] NDIV_MASK = DATA_W'(((64'd1 << NDIV_W) - 1) << NDIV_LSB);

  function automatic logic [PDIV_W:0] pick_prediv(input logic [DATA_W-1:0] word);
    logic [PDIV_W-1:0] fld;
    fld = word[PDIV_LSB +: PDIV_W];
    return (fld == '0) ? (PDIV_W+1)'(PDIV_DFLT) : {1'b0, fld};
  endfunction

  function automatic logic [DATA_W-1:0] splice_ndiv(input logic [DATA_W-1:0] word,
                                                    input logic [NDIV_W-1:0] val);
    return (word & ~NDIV_MASK) | (DATA_W'(val) << NDIV_LSB);
  endfunction

  assign prediv  = pick_prediv(ctrl_rd);
  assign ctrl_wr = splice_ndiv(ctrl_rd, ndiv);

  // R4: pre-divider used is never zero
  always_comb begin
    p_prediv_nonzero_r4: assert (prediv != '0);
  end

endmodule

// File: rtl/usbpll_div_seq.sv
module usbpll_div_seq
  import usbpll_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int RATE_W    = 32,
  parameter int DVD_W     = 34,
  parameter int NDIV_LSB  = 2,
  parameter int NDIV_W    = 10,
  parameter int PDIV_LSB  = 12,
  parameter int PDIV_W    = 3,
  parameter int PDIV_DFLT = 8,
  parameter logic [RATE_W-1:0] VCO_HZ     = 32'd1920000000,
  parameter logic [ADDR_W-1:0] CTRL_OFF   = 12'h164,
  parameter logic [ADDR_W-1:0] KEY_OFF    = 12'h180,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000EA68,
  parameter logic [DATA_W-1:0] LOCK_KEY   = 32'h00000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] ref_hz,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  localparam int PD_W = PDIV_W + 1;

  seq_state_t        state_q;
  logic [RATE_W-1:0] rate_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [NDIV_W-1:0] ndiv_q;
  logic              key_open_q;

  logic [PD_W-1:0]   prediv;
  logic [DATA_W-1:0] ctrl_new;
  logic [DVD_W-1:0]  dividend;
  logic [DVD_W-1:0]  quotient;
  logic              div_busy;
  logic              div_done;
  logic              div_go;
  logic              ndiv_ovf;
  logic              xfer_done;
  logic              accept_start;

  usbpll_ctl_field #(
    .DATA_W(DATA_W), .NDIV_LSB(NDIV_LSB), .NDIV_W(NDIV_W),
    .PDIV_LSB(PDIV_LSB), .PDIV_W(PDIV_W), .PDIV_DFLT(PDIV_DFLT)
  ) u_field (
    .ctrl_rd(ctrl_q),
    .ndiv   (ndiv_q),
    .prediv (prediv),
    .ctrl_wr(ctrl_new)
  );

  assign dividend = DVD_W'(VCO_HZ) * DVD_W'(prediv);
  assign div_go   = (state_q == S_DIV_GO);

  usbpll_divider #(.N_W(DVD_W), .D_W(RATE_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (div_go),
    .dividend(dividend),
    .divisor (rate_q),
    .busy    (div_busy),
    .done    (div_done),
    .quotient(quotient)
  );

  assign ndiv_ovf     = |(quotient >> NDIV_W);
  assign xfer_done    = bus_req && bus_ack;
  assign accept_start = (state_q == S_IDLE) && start;
  assign busy         = (state_q != S_IDLE);

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = CTRL_OFF;
    bus_wdata = '0;
    case (state_q)
      S_RD_CTRL:   begin bus_req = 1'b1; end
      S_WR_UNLOCK: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = KEY_OFF; bus_wdata = UNLOCK_KEY; end
      S_WR_CTRL:   begin bus_req = 1'b1; bus_we = 1'b1; bus_wdata = ctrl_new; end
      S_WR_LOCK:   begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = KEY_OFF; bus_wdata = LOCK_KEY; end
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      rate_q     <= '0;
      ctrl_q     <= '0;
      ndiv_q     <= '0;
      key_open_q <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          rate_q <= ref_hz;
          if (ref_hz == '0) begin
            done  <= 1'b1;
            error <= 1'b1;
          end else begin
            state_q <= S_RD_CTRL;
          end
        end
        S_RD_CTRL: if (xfer_done) begin
          ctrl_q  <= bus_rdata;
          state_q <= S_DIV_GO;
        end
        S_DIV_GO: state_q <= S_DIV_WAIT;
        S_DIV_WAIT: if (div_done) begin
          if (ndiv_ovf) begin
            done    <= 1'b1;
            error   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            ndiv_q  <= quotient[NDIV_W-1:0];
            state_q <= S_WR_UNLOCK;
          end
        end
        S_WR_UNLOCK: if (xfer_done) begin
          key_open_q <= 1'b1;
          state_q    <= S_WR_CTRL;
        end
        S_WR_CTRL: if (xfer_done) state_q <= S_WR_LOCK;
        S_WR_LOCK: if (xfer_done) begin
          key_open_q <= 1'b0;
          done       <= 1'b1;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R8: an unacknowledged request keeps its attributes
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: error only accompanies done
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  // R3: control word written only inside an open key window
  p_ctrl_wr_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == CTRL_OFF) |-> key_open_q);

  // R2: zero rate never leads to a bus request
  p_zero_rate_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_start && ref_hz == '0) |=> !bus_req);

  // R10: a start while busy does not disturb the captured rate
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(rate_q));

  // R7: divider never restarts while it is working
  p_div_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> !div_busy);

endmodule

// File: tb/usbpll_div_seq_tb.sv
module usbpll_div_seq_tb;
  localparam logic [11:0] CTRL_A = 12'h164;
  localparam logic [11:0] KEY_A  = 12'h180;
  localparam logic [31:0] UNLK   = 32'h0000EA68;
  localparam logic [31:0] NMASK  = 32'h00000FFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_hz = '0;
  logic        busy, done, error;
  logic        bus_req, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;

  int checks = 0;
  int failures = 0;

  logic [31:0] ctrl_mem = '0;
  logic [31:0] key_mem = '0;
  int          op_n = 0;
  logic        op_we  [8];
  logic [11:0] op_addr[8];
  logic [31:0] op_data[8];

  always #10 clk = ~clk;

  usbpll_div_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz),
    .busy(busy), .done(done), .error(error),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_prediv(input logic [31:0] c);
    logic [63:0] f;
    f = 64'((c >> 12) & 32'h7);
    return (f == 0) ? 64'd8 : f;
  endfunction

  function automatic logic [63:0] exp_ndiv(input logic [31:0] c, input logic [31:0] r);
    return (64'd1920000000 * exp_prediv(c)) / 64'(r);
  endfunction

  // register block model: random ack latency, checks request stability (R8)
  initial begin
    int          wait_n;
    logic        seen;
    logic [44:0] snap;
    wait_n = 0;
    seen = 1'b0;
    snap = '0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        seen = 1'b0;
        wait_n = int'($urandom % 4);
      end else if (bus_req) begin
        if (!seen) begin
          seen = 1'b1;
          snap = {bus_we, bus_addr, bus_wdata};
        end else begin
          check(snap == {bus_we, bus_addr, bus_wdata}, "R8 request held", 64'({bus_we, bus_addr, bus_wdata}), 64'(snap));
        end
        if (wait_n == 0) begin
          bus_ack = 1'b1;
          if (op_n < 8) begin
            op_we[op_n] = bus_we; op_addr[op_n] = bus_addr; op_data[op_n] = bus_wdata;
          end
          op_n++;
          if (!bus_we) begin
            bus_rdata = (bus_addr == CTRL_A) ? ctrl_mem : key_mem;
          end else if (bus_addr == CTRL_A) begin
            check(key_mem == UNLK, "R3 ctrl write while key open", 64'(key_mem), 64'(UNLK));
            ctrl_mem = bus_wdata;
          end else begin
            key_mem = bus_wdata;
          end
        end else begin
          wait_n--;
        end
      end
    end
  end

  task automatic run_pass(input logic [31:0] ctrl0, input logic [31:0] rate, input bit poke_busy);
    logic [63:0] q;
    bit got, err;
    got = 1'b0; err = 1'b0;
    ctrl_mem = ctrl0;
    key_mem = '0;
    op_n = 0;
    @(negedge clk);
    ref_hz = rate;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      check(busy == 1'b1, "R10 busy during pass", 64'(busy), 64'd1);
      ref_hz = 32'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 400 && !got; i++) begin
      if (done) begin got = 1'b1; err = error; end
      else @(negedge clk);
    end
    check(got, "R9 done reached", 64'(got), 64'd1);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", 64'(done), 64'd0);
    repeat (2) @(negedge clk);
    if (rate == 0) begin
      check(err == 1'b1, "R2 error on zero rate", 64'(err), 64'd1);
      check(op_n == 0, "R2 no bus access", 64'(op_n), 64'd0);
      return;
    end
    q = exp_ndiv(ctrl0, rate);
    if (q > 64'd1023) begin
      check(err == 1'b1, "R7 error on overflow", 64'(err), 64'd1);
      check(op_n == 1, "R7 only the read", 64'(op_n), 64'd1);
      check(ctrl_mem == ctrl0 && key_mem == 0, "R7 no write", 64'(ctrl_mem), 64'(ctrl0));
      return;
    end
    check(err == 1'b0, "R5 no error", 64'(err), 64'd0);
    check(op_n == 4, "R3 four accesses", 64'(op_n), 64'd4);
    if (op_n == 4) begin
      check(!op_we[0] && op_addr[0] == CTRL_A, "R3 op0 ctrl read", 64'({op_we[0], op_addr[0]}), 64'(CTRL_A));
      check(op_we[1] && op_addr[1] == KEY_A && op_data[1] == UNLK, "R3 op1 unlock",
            64'(op_data[1]), 64'(UNLK));
      check(op_we[2] && op_addr[2] == CTRL_A, "R3 op2 ctrl write", 64'({op_we[2], op_addr[2]}), 64'({1'b1, CTRL_A}));
      check(op_we[3] && op_addr[3] == KEY_A && op_data[3] == 0, "R3 op3 lock", 64'(op_data[3]), 64'd0);
    end
    check(64'((ctrl_mem & NMASK) >> 2) == q, "R5 R4 feedback divider", 64'((ctrl_mem & NMASK) >> 2), q);
    check((ctrl_mem & ~NMASK) == (ctrl0 & ~NMASK), "R6 other bits kept", 64'(ctrl_mem), 64'(ctrl0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !error && !bus_req, "R1 reset idle", 64'({busy, done, error, bus_req}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !bus_req, "R1 idle after release", 64'({busy, bus_req}), 64'd0);

    run_pass(32'hFFFF_0FFF, 32'd25000000, 1'b0);   // R4 zero field -> 8, expect 614
    check(exp_ndiv(32'hFFFF_0FFF, 32'd25000000) == 64'd614, "R4 default prediv 8", exp_ndiv(32'hFFFF_0FFF, 32'd25000000), 64'd614);
    run_pass(32'h0000_1000, 32'd0, 1'b0);          // R2
    run_pass(32'h0000_1000, 32'd1000000, 1'b0);    // R7 overflow
    run_pass(32'hA5A5_1003, 32'd1876832, 1'b0);    // R5 divider exactly 1023
    run_pass(32'h5A5A_1000, 32'd1875000, 1'b0);    // R7 divider exactly 1024
    run_pass(32'h1234_7FFF, 32'd100000000, 1'b0);  // R4 max field 7
    run_pass(32'h0000_2000, 32'd48000000, 1'b1);   // R10 start while busy

    for (int n = 0; n < 24; n++) begin
      logic [31:0] c, r;
      c = $urandom;
      r = 32'd10000000 + ($urandom % 32'd190000000);
      run_pass(c, r, n % 6 == 5);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule